// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block supplies the address for each beat of a four-beat memory burst. A load strobe captures a full starting address from the external address bus. After that, each clock edge on which the active-low advance input is asserted moves the burst on by one beat. Only the two least significant address bits change from beat to beat. Every higher bit keeps the value it had when the address was loaded.

A static order input picks one of two beat orders. In linear order the low bits count up by one and wrap modulo four. In interleaved order the low bits on beat n are the loaded low bits XOR n. Both orders come from one shared 2-bit beat counter. That counter is cleared on every load, and the low bits are formed from it and the saved starting bits. When the advance input is deasserted the burst is suspended and the address holds. A load may arrive on any cycle, including in the middle of a burst, and it always takes priority over advance.

The output is built combinationally from registered state. A load or advance that is sampled on a clock edge therefore appears at the output right after that edge. The access logic downstream uses this address. It decides read or write on its own and drives the memory.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset sets the output address to zero and clears the beat count.
- R2: When load_i is high on a clock edge, the output after that edge equals the full value of addr_i sampled on that edge.
- R3: When order_i is 0 (linear), the low two output bits after k advances since the last load are (loaded low bits + k) mod 4.
- R4: When order_i is 1 (interleaved), the low two output bits after k advances since the last load are the loaded low bits XOR (k mod 4).
- R5: Output bits above bit 1 change only on a load.
- R6: After four advances the low bits return to their loaded value, and they keep cycling with further advances.
- R7: When adv_n_i is high and load_i is low, the output address holds its value (suspend), and the beat count is kept for a later resume.
- R8: When load_i and advance are both asserted on the same edge, the load wins: the output equals the new addr_i with beat count zero.
- R9: Loads on consecutive cycles each take effect at once, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe: capture addr_i and restart the burst |
| adv_n_i | input | 1 | Advance enable, active low; high suspends the burst |
| order_i | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External starting address |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench sweeps both orders, all four starting low-bit values and several upper-bit patterns, and runs six advances past each load. A design that wraps wrongly shows up as a low-bit mismatch on the fifth or sixth beat. A design that mixes up the two orders fails for start values 01 and 11, because there the linear and XOR sequences differ. Suspends are placed inside interleaved bursts: a design that advanced while suspended, or lost its beat count across the pause, would hand out the wrong beat on resume. Load-with-advance and back-to-back loads are also covered. A design that gave advance priority would output the new address plus one beat instead of the new address itself.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
    } beat_state_t;

    function automatic logic [BEAT_W-1:0] beat_low(input beat_state_t st, input order_e ord);
        logic [BEAT_W-1:0] r;
        if (ord == ORDER_XOR) r = st.start ^ st.beat;
        else                  r = st.start + st.beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              adv_n_i,
    output logic [BEAT_W-1:0] beat_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)         beat_o <= '0;
        else if (load_i)   beat_o <= '0;
        else if (!adv_n_i) beat_o <= beat_o + 1'b1;
    end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)       base_o <= '0;
        else if (load_i) base_o <= addr_i;
    end
endmodule

// File: rtl/burst_order_mux.sv
module burst_order_mux
    import burst_pkg::*;
(
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic              order_i,
    output logic [BEAT_W-1:0] low_o
);
    beat_state_t st;
    always_comb begin
        st.start = start_i;
        st.beat  = beat_i;
        low_o    = beat_low(st, order_e'(order_i));
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] low_w;

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load_i),
        .addr_i (addr_i),
        .base_o (base_q)
    );

    burst_beat_ctr u_ctr (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .beat_o  (beat_q)
    );

    burst_order_mux u_mux (
        .start_i (base_q[BEAT_W-1:0]),
        .beat_i  (beat_q),
        .order_i (order_i),
        .low_o   (low_w)
    );

    generate
        if (UPPER_W > 0) begin : g_upper
            assign addr_o = {base_q[ADDR_W-1:BEAT_W], low_w};
        end else begin : g_low_only
            assign addr_o = low_w;
        end
    endgenerate
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              load_i,
    input logic              adv_n_i,
    input logic              order_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o
);
    // R2, R8: a load wins over advance and shows up in full right after the edge
    p_load_takes_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> addr_o == $past(addr_i));

    // R5: upper bits move only on a load
    p_upper_kept_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(addr_o[ADDR_W-1:2]));

    // R7: suspend holds the address while the order stays put
    p_suspend_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && adv_n_i) |=> ($past(order_i) != order_i || $stable(addr_o)));

    // R3: linear advance steps the low bits by one modulo four
    p_linear_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !adv_n_i && !order_i) |=>
            (order_i || addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (load_i),
    .adv_n_i (adv_n_i),
    .order_i (order_i),
    .addr_i  (addr_i),
    .addr_o  (addr_o)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst, load, adv_n, order;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;

    logic [AW-3:0] m_up;
    logic [1:0]    m_start;
    int            m_beat;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .load_i  (load),
        .adv_n_i (adv_n),
        .order_i (order),
        .addr_i  (addr_in),
        .addr_o  (addr_out)
    );

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [AW-1:0] expected();
        logic [1:0] lo;
        if (order) lo = m_start ^ 2'(m_beat % 4);
        else       lo = 2'((m_start + m_beat) % 4);
        return {m_up, lo};
    endfunction

    task automatic check(input string req);
        logic [AW-1:0] e;
        e = expected();
        checks++;
        if (addr_out !== e) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, addr_out, e);
        end
    endtask

    task automatic tick(input logic ld, input logic an, input logic [AW-1:0] a, input string req);
        load = ld; adv_n = an; addr_in = a;
        @(posedge clk); #2;
        if (ld) begin
            m_up = a[AW-1:2]; m_start = a[1:0]; m_beat = 0;
        end else if (!an) m_beat++;
        check(req);
    endtask

    initial begin
        rst = 1'b1; load = 1'b0; adv_n = 1'b1; order = 1'b0; addr_in = '1;
        m_up = '0; m_start = '0; m_beat = 0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset");
        rst = 1'b0;

        // exhaustive sweep: both orders, all starts, several upper patterns
        for (int o = 0; o < 2; o++) begin
            order = o[0];
            for (int s = 0; s < 4; s++) begin
                for (int u = 0; u < 3; u++) begin
                    logic [AW-3:0] up;
                    up = (u == 0) ? '0 : (u == 1) ? '1 : (AW-2)'(16'h2A5 + s);
                    tick(1'b1, 1'b1, {up, 2'(s)}, "R2 load");
                    for (int k = 0; k < 6; k++)
                        tick(1'b0, 1'b0, '0, (k == 3) ? "R6 wrap" :
                             (o == 1) ? "R4 interleaved R5" : "R3 linear R5");
                end
            end
        end

        // suspend mid-burst in interleaved order, then resume
        order = 1'b1;
        tick(1'b1, 1'b1, 12'h5A1, "R2 load");
        tick(1'b0, 1'b0, '0, "R4 beat1");
        for (int k = 0; k < 3; k++) tick(1'b0, 1'b1, 12'hFFF, "R7 suspend");
        tick(1'b0, 1'b0, '0, "R7 resume R4");
        tick(1'b0, 1'b0, '0, "R7 resume R4");

        // load with advance: load wins
        order = 1'b0;
        tick(1'b1, 1'b1, 12'h3C2, "R2 load");
        tick(1'b0, 1'b0, '0, "R3 step");
        tick(1'b1, 1'b0, 12'h811, "R8 load priority");
        tick(1'b0, 1'b0, '0, "R8 then step");

        // back-to-back loads
        for (int k = 0; k < 5; k++) tick(1'b1, k[0], AW'(12'h123 * (k + 1)), "R9 back-to-back");

        // reset mid-burst
        tick(1'b0, 1'b0, '0, "R3 step");
        rst = 1'b1; load = 1'b0; adv_n = 1'b0;
        @(posedge clk); #2;
        m_up = '0; m_start = '0; m_beat = 0;
        check("R1 reset mid-burst");
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule